// File: doc/BRIEF.md
# Signed-Count Arithmetic Shifter

This block shifts either one 16-bit register or a 32-bit register pair by a distance and direction taken from a signed 6-bit count. A positive count moves bits toward the most significant end and fills with zeros. A negative count moves bits toward the least significant end and copies the sign bit into the vacated positions. The block also produces negative, zero, overflow and carry flags. The overflow flag records whether the sign bit ever took a different value at any step of the shift, not only at the end.

The operand-fetch stage supplies four things: the named register's value, the value of the register that follows it, the low six bits of the source operand, and two mode bits. One mode bit selects single or double width. The other gives the parity of the named register. When the named register is odd in double mode, both halves of the pair are the same register. In that case a right shift becomes a 16-bit rotate. The result, the write enables for the two registers and the flags are registered and appear one cycle after `in_valid`. The register file stays outside the block.

Top module: `asft_shifter`

## Requirements
- R1: `shift_cnt` is read as a two's complement value from -32 to +31. Zero or positive means a left shift by that amount, and negative means a right shift by its magnitude. So 6'b011111 shifts left 31, 6'b000001 shifts left 1, 6'b111111 shifts right 1 and 6'b100000 shifts right 32.
- R2: With `dbl_mode`=0 the operand is `reg_val` (16 bits). Left shifts fill with zeros and right shifts fill with the sign bit. The result goes to `res_reg` with `wr_reg`=1, `wr_pair`=0 and `res_pair`=0. `reg_odd` has no effect in this mode.
- R3: With `dbl_mode`=1 and `reg_odd`=0 the operand is the 32-bit word {`reg_val`,`pair_val`}, with `reg_val` as bits 31:16. The result's bits 31:16 go to `res_reg` and bits 15:0 go to `res_pair`, and both write enables are 1.
- R4: With `dbl_mode`=1 and `reg_odd`=1, a left shift behaves as in R2 on `reg_val`. A right shift by m rotates `reg_val` right by m mod 16, so counts of 16 or less rotate by the count itself. Only `wr_reg` is 1, and `res_pair`=0.
- R5: `flag_c` is the last bit to leave the operand. On a left shift that is the bit leaving the most significant position, and on a right shift or rotate it is the bit leaving bit 0. Shifting past the operand width pushes out zeros on a left shift and copies of the sign on a right shift.
- R6: `flag_v` is 1 exactly when the operand's sign bit, after any single one-bit step of the shift, differs from its value before the shift. A plain right shift therefore never sets it.
- R7: `flag_n` equals bit 15 of `res_reg` in every mode. `flag_z` is 1 exactly when the whole result is zero: 32 bits in the mode of R3 and 16 bits otherwise.
- R8: A count of zero returns the operand unchanged with `flag_v`=0 and `flag_c`=0, and N and Z taken from the operand.
- R9: Outputs update on the clock edge that samples `in_valid`=1. `out_valid` is 1 in the next cycle only, and other outputs hold. Synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| dbl_mode | input | 1 | 1 selects the register-pair operation |
| reg_odd | input | 1 | Parity of the named register |
| reg_val | input | 16 | Value of the named register |
| pair_val | input | 16 | Value of the following register |
| shift_cnt | input | 6 | Low six bits of the source operand |
| out_valid | output | 1 | Result valid |
| res_reg | output | 16 | New value for the named register |
| res_pair | output | 16 | New value for the following register |
| wr_reg | output | 1 | Write enable, named register |
| wr_pair | output | 1 | Write enable, following register |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |
| flag_v | output | 1 | Sign changed during the shift |
| flag_c | output | 1 | Last bit shifted out |

## Verification
The bench sweeps all 64 counts over operands chosen around the sign bit: alternating patterns, a lone MSB, all ones and zero. It does this in single mode, even-pair mode and odd-pair mode, and compares each result with a one-bit-per-step model.

Several faults are targeted. A design that checked only the final sign for overflow would miss operands whose sign flips and then flips back. Taking the carry index without sign extension would give a wrong carry for right shifts of 17 to 32. Treating 6'b100000 as +32 would shift the wrong way. Rotating in place of arithmetic shifting in even-pair mode would return wrapped bits, and a lost `reg_odd` gate would enable the pair write in odd mode.

// File: rtl/asft_pkg.sv
package asft_pkg;

    parameter int WORD_W = 16;
    localparam int DBL_W = 2 * WORD_W;
    localparam int CNT_W = $clog2(DBL_W) + 1;
    localparam int EXT_W = 2 * DBL_W;
    localparam int IDX_W = $clog2(EXT_W);
    localparam int ROT_W = $clog2(WORD_W);

    typedef enum logic [1:0] {
        SK_NONE   = 2'd0,
        SK_LEFT   = 2'd1,
        SK_RIGHT  = 2'd2,
        SK_ROTATE = 2'd3
    } shift_kind_e;

    typedef struct packed {
        shift_kind_e      kind;
        logic [CNT_W-1:0] mag;
    } shift_cmd_t;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
        logic              n;
        logic              z;
        logic              v;
        logic              c;
    } shift_res_t;

    function automatic logic [CNT_W-1:0] count_magnitude(input logic [CNT_W-1:0] raw);
        return raw[CNT_W-1] ? (~raw + 1'b1) : raw;
    endfunction

endpackage

// File: rtl/asft_count_decode.sv
module asft_count_decode
    import asft_pkg::*;
(
    input  logic [CNT_W-1:0] raw_cnt,
    input  logic             dbl_mode,
    input  logic             reg_odd,
    output shift_cmd_t       cmd
);
    always_comb begin
        cmd.mag = count_magnitude(raw_cnt);
        if (raw_cnt == '0)
            cmd.kind = SK_NONE;
        else if (!raw_cnt[CNT_W-1])
            cmd.kind = SK_LEFT;
        else if (dbl_mode && reg_odd)
            cmd.kind = SK_ROTATE;
        else
            cmd.kind = SK_RIGHT;
    end
endmodule

// File: rtl/asft_linear_core.sv
module asft_linear_core
    import asft_pkg::*;
(
    input  logic [DBL_W-1:0] opnd,
    input  logic             go_left,
    input  logic             narrow,
    input  logic [CNT_W-1:0] mag,
    output logic [DBL_W-1:0] result,
    output logic             carry,
    output logic             sign_flip
);
    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] ext_sh;
    logic [DBL_W-1:0] diff;
    logic [DBL_W-1:0] win_mask;
    logic [IDX_W-1:0] base;
    logic [IDX_W-1:0] idx;
    logic [DBL_W-1:0] left_out;

    always_comb begin
        ext      = {{DBL_W{opnd[DBL_W-1]}}, opnd};
        diff     = opnd ^ {DBL_W{opnd[DBL_W-1]}};
        win_mask = ~({DBL_W{1'b1}} >> ({1'b0, mag} + 1'b1));
        base     = narrow ? IDX_W'(WORD_W) : '0;
        idx      = base + IDX_W'(mag) - 1'b1;
        ext_sh   = $signed(ext) >>> mag;
        left_out = opnd >> (IDX_W'(DBL_W) - IDX_W'(mag));
        if (go_left) begin
            result    = opnd << mag;
            carry     = left_out[0];
            sign_flip = |(diff & win_mask);
        end else begin
            result    = ext_sh[DBL_W-1:0];
            carry     = ext[idx];
            sign_flip = 1'b0;
        end
    end
endmodule

// File: rtl/asft_rotate_unit.sv
module asft_rotate_unit
    import asft_pkg::*;
(
    input  logic [WORD_W-1:0] opnd,
    input  logic [CNT_W-1:0]  mag,
    output logic [WORD_W-1:0] result,
    output logic              carry,
    output logic              sign_flip
);
    logic [2*WORD_W-1:0] doubled;
    logic [WORD_W-1:0]   seen_mask;
    logic [ROT_W-1:0]    amt;

    always_comb begin
        amt     = mag[ROT_W-1:0];
        doubled = {opnd, opnd} >> amt;
        result  = doubled[WORD_W-1:0];
        carry   = result[WORD_W-1];
        if (mag >= CNT_W'(WORD_W))
            seen_mask = '1;
        else
            seen_mask = ~({WORD_W{1'b1}} << mag);
        sign_flip = |((opnd ^ {WORD_W{opnd[WORD_W-1]}}) & seen_mask);
    end
endmodule

// File: rtl/asft_shifter.sv
module asft_shifter
    import asft_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              dbl_mode,
    input  logic              reg_odd,
    input  logic [WORD_W-1:0] reg_val,
    input  logic [WORD_W-1:0] pair_val,
    input  logic [CNT_W-1:0]  shift_cnt,
    output logic              out_valid,
    output logic [WORD_W-1:0] res_reg,
    output logic [WORD_W-1:0] res_pair,
    output logic              wr_reg,
    output logic              wr_pair,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);
    shift_cmd_t       cmd;
    shift_res_t       nxt;
    logic             wide;
    logic [DBL_W-1:0] opnd;
    logic [DBL_W-1:0] lin_res;
    logic             lin_c;
    logic             lin_v;
    logic [WORD_W-1:0] rot_res;
    logic             rot_c;
    logic             rot_v;
    logic [DBL_W-1:0] sel;

    assign wide = dbl_mode && !reg_odd;
    assign opnd = wide ? {reg_val, pair_val} : {reg_val, {WORD_W{1'b0}}};

    asft_count_decode u_dec (
        .raw_cnt (shift_cnt),
        .dbl_mode(dbl_mode),
        .reg_odd (reg_odd),
        .cmd     (cmd)
    );

    asft_linear_core u_lin (
        .opnd     (opnd),
        .go_left  (cmd.kind == SK_LEFT),
        .narrow   (!wide),
        .mag      (cmd.mag),
        .result   (lin_res),
        .carry    (lin_c),
        .sign_flip(lin_v)
    );

    asft_rotate_unit u_rot (
        .opnd     (reg_val),
        .mag      (cmd.mag),
        .result   (rot_res),
        .carry    (rot_c),
        .sign_flip(rot_v)
    );

    always_comb begin
        unique case (cmd.kind)
            SK_NONE: begin
                sel   = opnd;
                nxt.c = 1'b0;
                nxt.v = 1'b0;
            end
            SK_ROTATE: begin
                sel   = {rot_res, {WORD_W{1'b0}}};
                nxt.c = rot_c;
                nxt.v = rot_v;
            end
            default: begin
                sel   = lin_res;
                nxt.c = lin_c;
                nxt.v = lin_v;
            end
        endcase
        nxt.hi = sel[DBL_W-1:WORD_W];
        nxt.lo = wide ? sel[WORD_W-1:0] : '0;
        nxt.n  = nxt.hi[WORD_W-1];
        nxt.z  = wide ? (sel == '0) : (nxt.hi == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_reg   <= '0;
            res_pair  <= '0;
            wr_reg    <= 1'b0;
            wr_pair   <= 1'b0;
            flag_n    <= 1'b0;
            flag_z    <= 1'b0;
            flag_v    <= 1'b0;
            flag_c    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_reg  <= nxt.hi;
                res_pair <= nxt.lo;
                wr_reg   <= 1'b1;
                wr_pair  <= wide;
                flag_n   <= nxt.n;
                flag_z   <= nxt.z;
                flag_v   <= nxt.v;
                flag_c   <= nxt.c;
            end
        end
    end

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_single_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res_reg) && $stable(flag_v) && $stable(flag_c));
    p_reg_written_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> wr_reg);
    p_pair_we_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (wr_pair == $past(dbl_mode && !reg_odd)));
    p_pair_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid && !wr_pair |-> res_pair == '0);
    p_zero_count_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid && shift_cnt == '0 |=> res_reg == $past(reg_val) && !flag_v && !flag_c);
    p_right_no_v_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid && shift_cnt[CNT_W-1] && !(dbl_mode && reg_odd) |=> !flag_v);
    p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && flag_z |-> res_reg == '0 && !flag_n);
endmodule

// File: tb/asft_shifter_test.sv
module asft_shifter_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        dbl_mode;
    logic        reg_odd;
    logic [15:0] reg_val;
    logic [15:0] pair_val;
    logic [5:0]  shift_cnt;
    logic        out_valid;
    logic [15:0] res_reg;
    logic [15:0] res_pair;
    logic        wr_reg;
    logic        wr_pair;
    logic        flag_n;
    logic        flag_z;
    logic        flag_v;
    logic        flag_c;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    asft_shifter uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .dbl_mode(dbl_mode),
        .reg_odd(reg_odd), .reg_val(reg_val), .pair_val(pair_val),
        .shift_cnt(shift_cnt), .out_valid(out_valid), .res_reg(res_reg),
        .res_pair(res_pair), .wr_reg(wr_reg), .wr_pair(wr_pair),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one-bit-per-step reference
    task automatic model(input logic dbl, input logic odd, input logic [15:0] a,
                         input logic [15:0] b, input logic [5:0] cnt,
                         output logic [15:0] eh, output logic [15:0] el,
                         output logic en, output logic ez,
                         output logic ev, output logic ec);
        logic [31:0] val;
        logic        even;
        logic        s0;
        int          w;
        int          n;
        even = dbl && !odd;
        w    = even ? 32 : 16;
        val  = even ? {a, b} : {16'h0, a};
        n    = cnt[5] ? int'(cnt) - 64 : int'(cnt);
        s0   = val[w-1];
        ec   = 1'b0;
        ev   = 1'b0;
        for (int i = 0; i < n; i++) begin
            ec  = val[w-1];
            val = val << 1;
            if (w == 16) val[31:16] = 16'h0;
            if (val[w-1] != s0) ev = 1'b1;
        end
        for (int i = 0; i < -n; i++) begin
            ec = val[0];
            if (dbl && odd)
                val = {16'h0, val[0], val[15:1]};
            else if (w == 32)
                val = {val[31], val[31:1]};
            else
                val = {16'h0, val[15], val[15:1]};
            if (val[w-1] != s0) ev = 1'b1;
        end
        eh = even ? val[31:16] : val[15:0];
        el = even ? val[15:0] : 16'h0;
        en = eh[15];
        ez = even ? (val == 32'h0) : (val[15:0] == 16'h0);
    endtask

    task automatic run_op(input logic dbl, input logic odd, input logic [15:0] a,
                          input logic [15:0] b, input logic [5:0] cnt,
                          input string mtag);
        logic [15:0] eh, el;
        logic        en, ez, ev, ec;
        string       t;
        model(dbl, odd, a, b, cnt, eh, el, en, ez, ev, ec);
        @(negedge clk);
        in_valid  = 1'b1;
        dbl_mode  = dbl;
        reg_odd   = odd;
        reg_val   = a;
        pair_val  = b;
        shift_cnt = cnt;
        @(negedge clk);
        in_valid = 1'b0;
        t = (cnt == 6'd0) ? "R8" : mtag;
        check("R9", "out_valid", {31'h0, out_valid}, 32'h1);
        check(t, "res_reg", {16'h0, res_reg}, {16'h0, eh});
        check(t, "res_pair", {16'h0, res_pair}, {16'h0, el});
        check(t, "write enables", {30'h0, wr_reg, wr_pair}, {30'h0, 1'b1, dbl && !odd});
        check((cnt == 6'd0) ? "R8" : "R5", "flag_c", {31'h0, flag_c}, {31'h0, ec});
        check((cnt == 6'd0) ? "R8" : "R6", "flag_v", {31'h0, flag_v}, {31'h0, ev});
        check("R7", "flag_n/z", {30'h0, flag_n, flag_z}, {30'h0, en, ez});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] pats [8];
        pats[0] = 16'o1234; pats[1] = 16'h8000; pats[2] = 16'h7FFF; pats[3] = 16'hFFFF;
        pats[4] = 16'h0001; pats[5] = 16'hC000; pats[6] = 16'h0000; pats[7] = 16'h5A5A;
        rst = 1'b1; in_valid = 1'b0; dbl_mode = 1'b0; reg_odd = 1'b0;
        reg_val = '0; pair_val = '0; shift_cnt = '0;
        repeat (3) @(negedge clk);
        check("R9", "reset outputs",
              {res_reg, out_valid, wr_reg, wr_pair, flag_n, flag_z, flag_v, flag_c, 9'h0},
              32'h0);
        rst = 1'b0;

        // R2 example: 0o1234 left 3 -> 0o12340, flags clear
        run_op(1'b0, 1'b0, 16'o1234, 16'h0, 6'd3, "R2");
        check("R2", "example result", {16'h0, res_reg}, {16'h0, 16'o12340});
        check("R2", "example flags", {28'h0, flag_n, flag_z, flag_v, flag_c}, 32'h0);

        // R1 encodings
        run_op(1'b0, 1'b0, 16'h0001, 16'h0, 6'b011111, "R1");
        run_op(1'b0, 1'b0, 16'h4001, 16'h0, 6'b000001, "R1");
        run_op(1'b0, 1'b0, 16'h8002, 16'h0, 6'b111111, "R1");
        check("R1", "right 1 of 8002", {16'h0, res_reg}, 32'h0000C001);
        run_op(1'b1, 1'b0, 16'h8000, 16'h0001, 6'b100000, "R1");
        check("R1", "right 32 of negative pair", {res_reg, res_pair}, 32'hFFFFFFFF);

        // R9: no request -> out_valid low, outputs held
        @(negedge clk);
        check("R9", "idle out_valid", {31'h0, out_valid}, 32'h0);
        check("R9", "held res_pair", {16'h0, res_pair}, 32'h0000FFFF);

        for (int p = 0; p < 8; p++) begin
            for (int c = 0; c < 64; c++) begin
                run_op(1'b0, c[0], pats[p], pats[7 - p], 6'(c), "R2");
                run_op(1'b1, 1'b0, pats[p], pats[(p + 3) % 8], 6'(c), "R3");
                run_op(1'b1, 1'b1, pats[p], pats[(p + 5) % 8], 6'(c), "R4");
            end
        end

        // R4 rotate by 16 and by 4
        run_op(1'b1, 1'b1, 16'h1234, 16'hFFFF, 6'b110000, "R4");
        check("R4", "rotate 16 identity", {16'h0, res_reg}, 32'h00001234);
        run_op(1'b1, 1'b1, 16'h1234, 16'hFFFF, 6'b111100, "R4");
        check("R4", "rotate 4", {16'h0, res_reg}, 32'h00004123);

        // R6: sign flips and returns
        run_op(1'b0, 1'b0, 16'h4000, 16'h0, 6'd2, "R6");
        check("R6", "transient flip", {31'h0, flag_v}, 32'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule